// File: doc/BRIEF.md
# Self-Programming Command Window Controller

This block holds the command register for flash self-programming. Software writes a six-bit command code into it. An accepted code opens a short window, counted in clock cycles. A store-instruction strobe inside that window becomes a flash command. For a fuse/lock read, a load-instruction strobe inside its window has its read data replaced. When a window runs out without a strobe, the command clears by itself and the instruction strobes behave normally again.

A store strobe produces a one-cycle decoded pulse on the cycle after it. The pulse is one of: page-buffer fill (with word address and data), page erase, page write, buffer clear or signature read. A page erase or page write keeps the command held until the flash signals completion. A load strobe that hits an armed fuse/lock read drives the override select and a byte chosen by the pointer, in the same cycle. While the EEPROM is busy, the whole block is locked out.

Top module: `selfprog_cmd_ctrl`

## Requirements
- R1: Command bits sit at fixed positions: bit 0 enable, bit 1 page erase, bit 2 page write, bit 3 fuse/lock read, bit 4 buffer clear, bit 5 signature read. Readback returns {2'b00, command[5:0]}, so bits 7:6 always read 0.
- R2: Only the low-six-bit codes 6'h01, 6'h03, 6'h05, 6'h09, 6'h11 and 6'h21 are accepted, whatever bits 7:6 of the write hold. Any other code leaves the register unchanged.
- R3: An accepted code keeps the store window open for STORE_WIN (4) cycles after the write edge. If no store strobe arrives in that window, the register clears to 0.
- R4: With code 6'h01, a store strobe pulses buf_fill_o on the next cycle. The pulse carries the pointer with bit 0 forced to 0 and the store data word. The register then clears.
- R5: With code 6'h03 or 6'h05, a store strobe pulses page_erase_o or page_write_o. The code stays in the register until flash_done_i. Register writes made in the meantime are ignored.
- R6: With code 6'h11 or 6'h21, a store strobe pulses buf_clear_o or sig_read_o, and the register clears.
- R7: With code 6'h09, a load strobe within LOAD_WIN (3) cycles asserts rd_override_o in the same cycle. rd_data_o is then the fuse low byte for pointer 0, the lock byte for pointer 1, the fuse high byte for pointer 3, and 8'hFF for any other pointer. fuse_read_o pulses on the next cycle.
- R8: The lock byte carries the lock bits in bits 1:0 and ones in bits 7:2.
- R9: After a fuse/lock read completes, or after its load window runs out, the register is 0. Later loads see rd_override_o low.
- R10: While ee_busy_i is high, register writes are ignored, rd_override_o stays low and store strobes produce no pulse.
- R11: An asynchronous active-low reset clears the register, the windows and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Command register write strobe |
| reg_wdata_i | input | 8 | Command register write data |
| reg_rdata_o | output | 8 | Command register readback |
| store_i | input | 1 | Store-instruction strobe |
| load_i | input | 1 | Load-instruction strobe |
| zptr_i | input | PTR_W | Address pointer |
| store_data_i | input | DATA_W | Data word of the store instruction |
| ee_busy_i | input | 1 | EEPROM write in progress |
| flash_done_i | input | 1 | Flash erase/write completed |
| fuse_lo_i | input | 8 | Fuse low byte |
| fuse_hi_i | input | 8 | Fuse high byte |
| lock_i | input | LOCK_W | Lock bits |
| buf_fill_o | output | 1 | Page-buffer fill pulse |
| buf_addr_o | output | PTR_W | Page-buffer word address |
| buf_data_o | output | DATA_W | Page-buffer write data |
| page_erase_o | output | 1 | Page erase pulse |
| page_write_o | output | 1 | Page write pulse |
| buf_clear_o | output | 1 | Buffer clear pulse |
| sig_read_o | output | 1 | Signature read pulse |
| fuse_read_o | output | 1 | Fuse/lock read completed pulse |
| rd_override_o | output | 1 | Load data override select |
| rd_data_o | output | 8 | Override read data |

## Verification
Every one of the 64 low-six-bit codes is written, with varying upper bits. This separates the six accepted codes from their one-bit neighbours and checks that bits 7:6 play no part. The store strobe is then delayed by 0 to 5 idle cycles, and the load strobe by 0 to 3, which locates both window edges exactly. Each load delay is tried at all four pointer values, so a wrong byte selection cannot hide behind a coincident value. Separate runs hold a page operation against flash_done_i and raise ee_busy_i against each kind of access.

// File: rtl/spmc_pkg.sv
package spmc_pkg;
  localparam int CMD_W  = 6;
  localparam int B_EN   = 0;
  localparam int B_ERS  = 1;
  localparam int B_WR   = 2;
  localparam int B_FUSE = 3;
  localparam int B_CLR  = 4;
  localparam int B_SIG  = 5;

  typedef enum logic [2:0] {
    OP_NONE, OP_FILL, OP_ERASE, OP_WRITE, OP_CLR, OP_SIG, OP_FUSE
  } op_e;
endpackage

// File: rtl/spmc_decode.sv
module spmc_decode
  import spmc_pkg::*;
(
  input  logic [CMD_W-1:0] pat_i,
  output logic             valid_o,
  output op_e              op_o
);
  logic [CMD_W-1:0] hi;
  assign hi = pat_i & ~(CMD_W'(1) << B_EN);

  always_comb begin
    op_o = OP_NONE;
    if (pat_i[B_EN]) begin
      unique case (hi)
        '0:                   op_o = OP_FILL;
        CMD_W'(1) << B_ERS:   op_o = OP_ERASE;
        CMD_W'(1) << B_WR:    op_o = OP_WRITE;
        CMD_W'(1) << B_FUSE:  op_o = OP_FUSE;
        CMD_W'(1) << B_CLR:   op_o = OP_CLR;
        CMD_W'(1) << B_SIG:   op_o = OP_SIG;
        default:              op_o = OP_NONE;
      endcase
    end
  end

  assign valid_o = (op_o != OP_NONE);
endmodule

// File: rtl/spmc_window.sv
module spmc_window #(
  parameter int WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hit_i,
  output logic open_o,
  output logic expire_o
);
  localparam int CW = $clog2(WIN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(WIN);
    else if (hit_i)         cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign open_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1)) && !hit_i && !start_i;
endmodule

// File: rtl/spmc_fuse_mux.sv
module spmc_fuse_mux #(
  parameter int PTR_W  = 16,
  parameter int LOCK_W = 2
) (
  input  logic [PTR_W-1:0]  zptr_i,
  input  logic [7:0]        fuse_lo_i,
  input  logic [7:0]        fuse_hi_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic [7:0]        byte_o
);
  logic [7:0] lock_byte;
  assign lock_byte = {{(8-LOCK_W){1'b1}}, lock_i};

  always_comb begin
    unique case (zptr_i)
      PTR_W'(0): byte_o = fuse_lo_i;
      PTR_W'(1): byte_o = lock_byte;
      PTR_W'(3): byte_o = fuse_hi_i;
      default:   byte_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/selfprog_cmd_ctrl.sv
module selfprog_cmd_ctrl
  import spmc_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int DATA_W    = 16,
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3,
  parameter int LOCK_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              store_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  zptr_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic              ee_busy_i,
  input  logic              flash_done_i,
  input  logic [7:0]        fuse_lo_i,
  input  logic [7:0]        fuse_hi_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic              buf_fill_o,
  output logic [PTR_W-1:0]  buf_addr_o,
  output logic [DATA_W-1:0] buf_data_o,
  output logic              page_erase_o,
  output logic              page_write_o,
  output logic              buf_clear_o,
  output logic              sig_read_o,
  output logic              fuse_read_o,
  output logic              rd_override_o,
  output logic [7:0]        rd_data_o
);
  logic [CMD_W-1:0] cmd_q;
  logic             busy_q;
  logic             wr_ok, cur_ok, accept, st_hit, ld_hit;
  logic             st_open, st_exp, ld_open, ld_exp;
  op_e              wr_op, cur_op;
  logic [7:0]       fuse_byte;

  spmc_decode u_dec_wr  (.pat_i(reg_wdata_i[CMD_W-1:0]), .valid_o(wr_ok),  .op_o(wr_op));
  spmc_decode u_dec_cur (.pat_i(cmd_q),                  .valid_o(cur_ok), .op_o(cur_op));

  assign accept = reg_we_i && !ee_busy_i && !busy_q && wr_ok;
  assign st_hit = store_i && cur_ok && st_open && !ee_busy_i && !busy_q;
  assign ld_hit = load_i && (cur_op == OP_FUSE) && ld_open && !ee_busy_i;

  spmc_window #(.WIN(STORE_WIN)) u_st_win (
    .clk_i, .rst_ni, .start_i(accept), .hit_i(st_hit),
    .open_o(st_open), .expire_o(st_exp)
  );

  spmc_window #(.WIN(LOAD_WIN)) u_ld_win (
    .clk_i, .rst_ni, .start_i(accept), .hit_i(ld_hit),
    .open_o(ld_open), .expire_o(ld_exp)
  );

  spmc_fuse_mux #(.PTR_W(PTR_W), .LOCK_W(LOCK_W)) u_fuse_mux (
    .zptr_i, .fuse_lo_i, .fuse_hi_i, .lock_i, .byte_o(fuse_byte)
  );

  // command register and long-operation hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
    end else if (accept) begin
      cmd_q  <= reg_wdata_i[CMD_W-1:0];
    end else if (busy_q) begin
      if (flash_done_i) begin
        cmd_q  <= '0;
        busy_q <= 1'b0;
      end
    end else if (st_hit) begin
      if (cur_op == OP_ERASE || cur_op == OP_WRITE) busy_q <= 1'b1;
      else                                          cmd_q  <= '0;
    end else if (ld_hit) begin
      cmd_q <= '0;
    end else if (st_exp || (ld_exp && cur_op == OP_FUSE)) begin
      cmd_q <= '0;
    end
  end

  // registered command pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_fill_o   <= 1'b0;
      buf_addr_o   <= '0;
      buf_data_o   <= '0;
      page_erase_o <= 1'b0;
      page_write_o <= 1'b0;
      buf_clear_o  <= 1'b0;
      sig_read_o   <= 1'b0;
      fuse_read_o  <= 1'b0;
    end else begin
      buf_fill_o   <= 1'b0;
      page_erase_o <= 1'b0;
      page_write_o <= 1'b0;
      buf_clear_o  <= 1'b0;
      sig_read_o   <= 1'b0;
      fuse_read_o  <= ld_hit && !accept;
      if (st_hit && !accept) begin
        unique case (cur_op)
          OP_FILL: begin
            buf_fill_o <= 1'b1;
            buf_addr_o <= {zptr_i[PTR_W-1:1], 1'b0};
            buf_data_o <= store_data_i;
          end
          OP_ERASE: page_erase_o <= 1'b1;
          OP_WRITE: page_write_o <= 1'b1;
          OP_CLR:   buf_clear_o  <= 1'b1;
          OP_SIG:   sig_read_o   <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  assign rd_override_o = ld_hit;
  assign rd_data_o     = ld_hit ? fuse_byte : 8'h00;
  assign reg_rdata_o   = {{(8-CMD_W){1'b0}}, cmd_q};
endmodule

// File: rtl/spmc_checker.sv
module spmc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] reg_rdata_o,
  input logic       store_i,
  input logic       load_i,
  input logic       ee_busy_i,
  input logic       buf_fill_o,
  input logic       page_erase_o,
  input logic       page_write_o,
  input logic       buf_clear_o,
  input logic       sig_read_o,
  input logic       fuse_read_o,
  input logic       rd_override_o
);
  assert_upper_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:6] == 2'b00);

  assert_single_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_rdata_o[5:1]) && (reg_rdata_o[5:1] == 5'b0 || reg_rdata_o[0]));

  assert_fill_needs_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_fill_o |-> $past(store_i));

  assert_page_op_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page_erase_o || page_write_o) |-> reg_rdata_o[0]);

  assert_one_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_fill_o, page_erase_o, page_write_o, buf_clear_o, sig_read_o, fuse_read_o}));

  assert_override_armed_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_override_o |-> (load_i && reg_rdata_o[3] && reg_rdata_o[0]));

  assert_read_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_read_o |-> !reg_rdata_o[3]);

  assert_ee_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_busy_i |-> !rd_override_o);
endmodule

bind selfprog_cmd_ctrl spmc_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_rdata_o(reg_rdata_o), .store_i(store_i),
  .load_i(load_i), .ee_busy_i(ee_busy_i), .buf_fill_o(buf_fill_o),
  .page_erase_o(page_erase_o), .page_write_o(page_write_o),
  .buf_clear_o(buf_clear_o), .sig_read_o(sig_read_o), .fuse_read_o(fuse_read_o),
  .rd_override_o(rd_override_o)
);

// File: tb/sim_selfprog_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_selfprog_cmd_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        store_i = 1'b0, load_i = 1'b0;
  logic [15:0] zptr_i = '0, store_data_i = '0;
  logic        ee_busy_i = 1'b0, flash_done_i = 1'b0;
  logic [7:0]  fuse_lo_i = 8'h5A, fuse_hi_i = 8'hC3;
  logic [1:0]  lock_i = 2'b10;
  logic        buf_fill_o, page_erase_o, page_write_o, buf_clear_o, sig_read_o;
  logic        fuse_read_o, rd_override_o;
  logic [15:0] buf_addr_o, buf_data_o;
  logic [7:0]  rd_data_o;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  selfprog_cmd_ctrl u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h want %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  function automatic bit legal(input logic [5:0] p);
    return p == 6'h01 || p == 6'h03 || p == 6'h05 || p == 6'h09 || p == 6'h11 || p == 6'h21;
  endfunction

  function automatic logic [7:0] fuse_exp(input int z);
    case (z)
      0: return fuse_lo_i;
      1: return {6'b111111, lock_i};
      3: return fuse_hi_i;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got %h want %h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(2);
    check("R11 reset readback", reg_rdata_o, 0);
    check("R11 reset pulses", {buf_fill_o, page_erase_o, page_write_o, buf_clear_o, sig_read_o, fuse_read_o}, 0);
    rst_ni = 1'b1;
    idle(1);

    // R2 / R1: sweep all codes with varying upper bits
    for (int i = 0; i < 64; i++) begin
      wr({i[1:0], i[5:0]});
      check("R2 code accept", reg_rdata_o, legal(i[5:0]) ? {2'b00, i[5:0]} : 8'h00);
      idle(6);
      check("R3 auto clear", reg_rdata_o, 0);
    end

    // R3 / R4: store window edge
    for (int k = 0; k <= 5; k++) begin
      wr(8'h01);
      idle(k);
      store_i = 1'b1; zptr_i = 16'h1235 + 16'(k); store_data_i = 16'hA000 + 16'(k);
      @(negedge clk_i);
      store_i = 1'b0;
      check("R3 store window", buf_fill_o, k <= 3);
      if (k <= 3) begin
        check("R4 fill addr", buf_addr_o, (16'h1235 + 16'(k)) & 16'hFFFE);
        check("R4 fill data", buf_data_o, 16'hA000 + 16'(k));
      end
      check("R4 cleared", reg_rdata_o, 0);
      idle(5);
    end

    // R5: erase then write, held until done
    for (int j = 0; j < 2; j++) begin
      logic [7:0] c;
      c = (j == 0) ? 8'h03 : 8'h05;
      wr(c);
      store_i = 1'b1;
      @(negedge clk_i);
      store_i = 1'b0;
      check("R5 erase pulse", page_erase_o, j == 0);
      check("R5 write pulse", page_write_o, j == 1);
      wr(8'h01);
      idle(8);
      check("R5 held", reg_rdata_o, c);
      store_i = 1'b1;
      @(negedge clk_i);
      store_i = 1'b0;
      check("R5 no repeat", {page_erase_o, page_write_o, buf_fill_o}, 0);
      flash_done_i = 1'b1;
      @(negedge clk_i);
      flash_done_i = 1'b0;
      check("R5 done clears", reg_rdata_o, 0);
    end

    // R6: clear and signature
    wr(8'h11); idle(1);
    store_i = 1'b1; @(negedge clk_i); store_i = 1'b0;
    check("R6 clear pulse", {buf_clear_o, sig_read_o}, 2'b10);
    check("R6 cleared", reg_rdata_o, 0);
    wr(8'h21); idle(3);
    store_i = 1'b1; @(negedge clk_i); store_i = 1'b0;
    check("R6 sig pulse", {buf_clear_o, sig_read_o}, 2'b01);
    check("R6 cleared", reg_rdata_o, 0);
    idle(5);

    // R7 / R8 / R9: load window and pointer decode
    for (int z = 0; z < 4; z++) begin
      for (int k = 0; k <= 3; k++) begin
        wr(8'h09);
        idle(k);
        load_i = 1'b1; zptr_i = 16'(z);
        #1;
        check("R7 override", rd_override_o, k <= 2);
        if (k <= 2) check((z == 1) ? "R8 lock byte" : "R7 fuse byte", rd_data_o, fuse_exp(z));
        @(negedge clk_i);
        load_i = 1'b0;
        check("R7 fuse pulse", fuse_read_o, k <= 2);
        check("R9 cleared", reg_rdata_o, 0);
        idle(5);
      end
    end
    load_i = 1'b1; zptr_i = 16'h0;
    #1;
    check("R9 normal load", rd_override_o, 0);
    @(negedge clk_i);
    load_i = 1'b0;

    // R10: EEPROM busy
    ee_busy_i = 1'b1;
    wr(8'h01);
    check("R10 write blocked", reg_rdata_o, 0);
    ee_busy_i = 1'b0;
    wr(8'h09);
    ee_busy_i = 1'b1; load_i = 1'b1; zptr_i = 16'h0;
    #1;
    check("R10 read suppressed", rd_override_o, 0);
    @(negedge clk_i);
    load_i = 1'b0; ee_busy_i = 1'b0;
    idle(5);
    wr(8'h01);
    ee_busy_i = 1'b1; store_i = 1'b1;
    @(negedge clk_i);
    store_i = 1'b0; ee_busy_i = 1'b0;
    check("R10 store suppressed", buf_fill_o, 0);
    idle(5);

    // R11: asynchronous reset mid-command
    wr(8'h09);
    rst_ni = 1'b0;
    #1;
    check("R11 async clear", reg_rdata_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(1);
    load_i = 1'b1;
    #1;
    check("R11 window cleared", rd_override_o, 0);
    @(negedge clk_i);
    load_i = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule